// File: doc/BRIEF.md
# Single-Wire Device Session Controller

This block is the device-side session state machine of a half-duplex, single-wire authentication peripheral. An external line decoder turns the wire activity into one-cycle pulses: a wake token and the sleep, idle, command and transmit flags. The decoder also delivers the received command block byte by byte. The controller keeps track of the device's power and session state: asleep, awake and idle, receiving a block, busy executing, or paused. It pulses a reset to the command engine and I/O buffer whenever the device drops back to sleep. It raises a response strobe with a response kind and code when a transmit flag is to be answered.

A session watchdog starts at each wake and returns the device to sleep when it runs out, so a host that has lost synchronisation always recovers. A pause command, with an optional address that is compared against a fused identity, parks every device except the chosen one on a shared wire. A parked device ignores the line entirely until the watchdog ends its session. Once the engine has finished, a transmit flag replays the stored result, so the host can retry after a bad checksum.

Top module: `sc_session_ctrl`

## Requirements
- R1: After reset the state output is sleep (0), and eng_rst_o, resp_req_o, resp_kind_o and resp_code_o are all zero.
- R2: In sleep, only a wake token has any effect. It moves the state to idle (1) on the next cycle. Every other flag, byte or status input leaves the state at sleep and produces no strobe.
- R3: The first transmit flag accepted in idle after a wake yields one resp_req_o cycle with kind sync (1) and code 0x11. A later transmit flag with nothing pending yields no strobe.
- R4: A sleep flag in idle, receive (2) or busy (3) moves the state to sleep on the next cycle. In that same cycle eng_rst_o is high for exactly one cycle.
- R5: The device stays out of sleep for exactly WDOG_CYC cycles after the edge that accepts a wake. It then enters sleep with a one-cycle eng_rst_o pulse, whatever state it was in.
- R6: A block whose last byte arrives with parse_err high returns the state to idle. Each transmit flag that follows answers with kind error (2) and code ERR_FMT (default 0x03), until the next command flag.
- R7: A completed block whose first byte is not the pause opcode (0x01) moves the state to busy. A transmit flag in busy produces no strobe.
- R8: exec_done in busy returns the state to idle. Every transmit flag after that answers with kind result (3) and code 0x00, until the next command flag or wake.
- R9: A completed pause block (first byte 0x01) enters pause (4) when it has no second byte, or when the low 4 bits of its second byte equal fuse_id.
- R10: A pause block whose address does not match fuse_id returns the state to idle with no strobe, and later commands are still accepted.
- R11: In pause, every token, flag, byte and status input is ignored. The state changes only at watchdog expiry, to sleep, and a wake token after that is honoured.
- R12: An idle flag during receive discards the partial block and returns the state to idle. In idle it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_tok | input | 1 | Decoded wake token pulse |
| sleep_flg | input | 1 | Decoded sleep flag pulse |
| idle_flg | input | 1 | Decoded idle flag pulse |
| cmd_flg | input | 1 | Decoded command flag pulse |
| xmit_flg | input | 1 | Decoded transmit flag pulse |
| byte_vld | input | 1 | Received command byte valid |
| byte_dat | input | 8 | Received command byte |
| byte_end | input | 1 | With byte_vld: this byte ends the block |
| parse_err | input | 1 | With the last byte: the parser found a format error |
| exec_done | input | 1 | Engine finished the current command |
| fuse_id | input | ID_W | Fused device identity |
| state_o | output | 3 | Session state: 0 sleep, 1 idle, 2 receive, 3 busy, 4 pause |
| eng_rst_o | output | 1 | One-cycle reset of the command engine and I/O buffer |
| resp_req_o | output | 1 | Response request strobe |
| resp_kind_o | output | 2 | Response kind: 1 sync, 2 error, 3 result, 0 none |
| resp_code_o | output | 8 | Response code byte, zero without a strobe |

## Verification
The hardest situation to reach is a device parked in pause that is hit by a burst of wake tokens, transmit flags, sleep flags and whole command blocks, and then leaves only when the watchdog runs out. A reset cannot help here, so the bench first sends a pause block whose address matches the fuse, then drives that noise directly and counts the cycles from the accepting wake until sleep. The random phase biases its bytes toward the pause opcode and toward matching and non-matching addresses, so paused sessions of both lengths come up again and again.

// File: rtl/sc_pkg.sv
package sc_pkg;
   typedef enum logic [2:0] {
      ST_SLEEP = 3'd0,
      ST_IDLE  = 3'd1,
      ST_RECV  = 3'd2,
      ST_BUSY  = 3'd3,
      ST_PAUSE = 3'd4
   } sc_state_e;

   typedef enum logic [1:0] {
      RK_NONE   = 2'd0,
      RK_SYNC   = 2'd1,
      RK_ERROR  = 2'd2,
      RK_RESULT = 2'd3
   } sc_rkind_e;

   localparam logic [7:0] SC_SYNC_CODE   = 8'h11;
   localparam logic [7:0] SC_RESULT_CODE = 8'h00;
endpackage

// File: rtl/sc_wdog.sv
module sc_wdog #(
   parameter int unsigned CYC = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic expire
);
   localparam int unsigned CW = $clog2(CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(CYC - 1);

   if (CYC < 2) begin : g_bad_cyc
      $error("sc_wdog: CYC must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign expire = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= '0;
      else if (run && !expire) cnt_q <= cnt_q + 1'b1;
   end

   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   assert_expire_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !run);
endmodule

// File: rtl/sc_addr_match.sv
module sc_addr_match #(
   parameter int unsigned ID_W          = 4,
   parameter bit          ADDR_OPTIONAL = 1'b1
) (
   input  logic            have_addr,
   input  logic [ID_W-1:0] addr,
   input  logic [ID_W-1:0] fuse,
   output logic            hit
);
   if (ID_W < 1 || ID_W > 8) begin : g_bad_w
      $error("sc_addr_match: ID_W must be 1..8");
   end

   if (ADDR_OPTIONAL) begin : g_opt
      assign hit = !have_addr || (addr == fuse);
   end else begin : g_req
      assign hit = have_addr && (addr == fuse);
   end
endmodule

// File: rtl/sc_resp_unit.sv
module sc_resp_unit
   import sc_pkg::*;
#(
   parameter logic [7:0] ERR_CODE = 8'h03
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm,
   input  logic       drop,
   input  logic       mark_err,
   input  logic       mark_res,
   input  logic       xmit_ok,
   output logic       req_o,
   output logic [1:0] kind_o,
   output logic [7:0] code_o
);
   logic      sync_q, err_q, res_q;
   logic      req_q;
   sc_rkind_e kind_q;
   logic [7:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         err_q  <= 1'b0;
         res_q  <= 1'b0;
         req_q  <= 1'b0;
         kind_q <= RK_NONE;
         code_q <= '0;
      end else begin
         req_q  <= 1'b0;
         kind_q <= RK_NONE;
         code_q <= '0;
         if (arm) begin
            sync_q <= 1'b1;
            err_q  <= 1'b0;
            res_q  <= 1'b0;
         end else begin
            if (drop) begin
               err_q <= 1'b0;
               res_q <= 1'b0;
            end
            if (mark_err) err_q <= 1'b1;
            if (mark_res) res_q <= 1'b1;
            if (xmit_ok) begin
               if (sync_q) begin
                  req_q  <= 1'b1;
                  kind_q <= RK_SYNC;
                  code_q <= SC_SYNC_CODE;
                  sync_q <= 1'b0;
               end else if (err_q) begin
                  req_q  <= 1'b1;
                  kind_q <= RK_ERROR;
                  code_q <= ERR_CODE;
               end else if (res_q) begin
                  req_q  <= 1'b1;
                  kind_q <= RK_RESULT;
                  code_q <= SC_RESULT_CODE;
               end
            end
         end
      end
   end

   assign req_o  = req_q;
   assign kind_o = kind_q;
   assign code_o = code_q;

   assert_sync_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_q && xmit_ok && !arm) |=> (req_o && code_o == SC_SYNC_CODE));

   assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !xmit_ok |=> !req_o);
endmodule

// File: rtl/sc_session_ctrl.sv
module sc_session_ctrl
   import sc_pkg::*;
#(
   parameter int unsigned WDOG_CYC      = 4096,
   parameter int unsigned ID_W          = 4,
   parameter logic [7:0]  OPC_PAUSE     = 8'h01,
   parameter logic [7:0]  ERR_FMT       = 8'h03,
   parameter bit          ADDR_OPTIONAL = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wake_tok,
   input  logic            sleep_flg,
   input  logic            idle_flg,
   input  logic            cmd_flg,
   input  logic            xmit_flg,
   input  logic            byte_vld,
   input  logic [7:0]      byte_dat,
   input  logic            byte_end,
   input  logic            parse_err,
   input  logic            exec_done,
   input  logic [ID_W-1:0] fuse_id,
   output logic [2:0]      state_o,
   output logic            eng_rst_o,
   output logic            resp_req_o,
   output logic [1:0]      resp_kind_o,
   output logic [7:0]      resp_code_o
);
   localparam int unsigned NB_W = 2;

   if (ERR_FMT == SC_SYNC_CODE) begin : g_bad_err
      $error("sc_session_ctrl: ERR_FMT must differ from the sync code");
   end

   sc_state_e       state_q, state_d;
   logic [NB_W-1:0] nb_q;
   logic [7:0]      op_q;
   logic [ID_W-1:0] addr_q;
   logic            eng_rst_q;

   logic awake, wd_exp, go_sleep;
   logic arm, drop, mk_err, mk_res, xok;
   logic end_blk, have_addr, addr_hit;
   logic [7:0]      end_op;
   logic [ID_W-1:0] end_addr;

   assign awake     = (state_q != ST_SLEEP);
   assign end_op    = (nb_q == '0) ? byte_dat : op_q;
   assign have_addr = (nb_q != '0);
   assign end_addr  = (nb_q == NB_W'(1)) ? byte_dat[ID_W-1:0] : addr_q;
   assign end_blk   = (state_q == ST_RECV) && byte_vld && byte_end &&
                      !wd_exp && !sleep_flg && !idle_flg;

   sc_wdog #(.CYC(WDOG_CYC)) wdog_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (arm),
      .run    (awake),
      .expire (wd_exp)
   );

   sc_addr_match #(.ID_W(ID_W), .ADDR_OPTIONAL(ADDR_OPTIONAL)) match_i (
      .have_addr (have_addr),
      .addr      (end_addr),
      .fuse      (fuse_id),
      .hit       (addr_hit)
   );

   always_comb begin
      state_d  = state_q;
      go_sleep = 1'b0;
      arm      = 1'b0;
      drop     = 1'b0;
      mk_err   = 1'b0;
      mk_res   = 1'b0;
      xok      = 1'b0;
      if (state_q == ST_SLEEP) begin
         if (wake_tok) begin
            state_d = ST_IDLE;
            arm     = 1'b1;
         end
      end else if (wd_exp) begin
         state_d  = ST_SLEEP;
         go_sleep = 1'b1;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (sleep_flg) begin
                  state_d  = ST_SLEEP;
                  go_sleep = 1'b1;
               end else if (cmd_flg) begin
                  state_d = ST_RECV;
                  drop    = 1'b1;
               end else if (xmit_flg) begin
                  xok = 1'b1;
               end
            end
            ST_RECV: begin
               if (sleep_flg) begin
                  state_d  = ST_SLEEP;
                  go_sleep = 1'b1;
               end else if (idle_flg) begin
                  state_d = ST_IDLE;
               end else if (end_blk) begin
                  if (parse_err) begin
                     state_d = ST_IDLE;
                     mk_err  = 1'b1;
                  end else if (end_op == OPC_PAUSE) begin
                     state_d = addr_hit ? ST_PAUSE : ST_IDLE;
                  end else begin
                     state_d = ST_BUSY;
                  end
               end
            end
            ST_BUSY: begin
               if (sleep_flg) begin
                  state_d  = ST_SLEEP;
                  go_sleep = 1'b1;
               end else if (exec_done) begin
                  state_d = ST_IDLE;
                  mk_res  = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_SLEEP;
         eng_rst_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         eng_rst_q <= go_sleep;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nb_q   <= '0;
         op_q   <= '0;
         addr_q <= '0;
      end else if (state_q != ST_RECV) begin
         nb_q <= '0;
      end else if (byte_vld && !byte_end) begin
         if (nb_q == '0)       op_q   <= byte_dat;
         if (nb_q == NB_W'(1)) addr_q <= byte_dat[ID_W-1:0];
         if (nb_q != NB_W'(2)) nb_q   <= nb_q + 1'b1;
      end
   end

   sc_resp_unit #(.ERR_CODE(ERR_FMT)) resp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .drop     (drop),
      .mark_err (mk_err),
      .mark_res (mk_res),
      .xmit_ok  (xok),
      .req_o    (resp_req_o),
      .kind_o   (resp_kind_o),
      .code_o   (resp_code_o)
   );

   assign state_o   = state_q;
   assign eng_rst_o = eng_rst_q;

   assert_sleep_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP && !wake_tok) |=> (state_q == ST_SLEEP && !resp_req_o));

   assert_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP && wake_tok) |=> state_q == ST_IDLE);

   assert_sleep_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_flg && (state_q == ST_IDLE || state_q == ST_RECV || state_q == ST_BUSY))
      |=> (state_q == ST_SLEEP && eng_rst_o));

   assert_rst_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rst_o |=> !eng_rst_o);

   assert_busy_deaf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_BUSY |=> !resp_req_o);

   assert_perr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (end_blk && parse_err) |=> state_q == ST_IDLE);

   assert_pause_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PAUSE && !wd_exp) |=> state_q == ST_PAUSE);

   assert_pause_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PAUSE && wd_exp) |=> (state_q == ST_SLEEP && eng_rst_o));
endmodule

// File: tb/sc_session_ctrl_tb.sv
module sc_session_ctrl_tb_top;
   localparam int W = 300;
   localparam logic [3:0] FUSE = 4'hA;
   localparam logic [2:0] S_SLP = 3'd0, S_IDL = 3'd1, S_RCV = 3'd2,
                          S_BSY = 3'd3, S_PAU = 3'd4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wake_tok = 0, sleep_flg = 0, idle_flg = 0, cmd_flg = 0, xmit_flg = 0;
   logic byte_vld = 0, byte_end = 0, parse_err = 0, exec_done = 0;
   logic [7:0] byte_dat = '0;
   logic [2:0] state_o;
   logic eng_rst_o, resp_req_o;
   logic [1:0] resp_kind_o;
   logic [7:0] resp_code_o;

   int n_run = 0, n_fail = 0, cyc_n = 0;

   // bench model of the requirements
   logic [2:0] m_st = S_SLP;
   int         m_cnt = 0;
   logic       m_sync = 0, m_err = 0, m_res = 0;
   int         m_nb = 0;
   logic [7:0] m_op = '0;
   logic [3:0] m_addr = '0;
   logic       e_rst = 0, e_req = 0;
   logic [1:0] e_kind = '0;
   logic [7:0] e_code = '0;

   always #4 clk = ~clk;

   sc_session_ctrl #(.WDOG_CYC(W), .ID_W(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .wake_tok(wake_tok), .sleep_flg(sleep_flg),
      .idle_flg(idle_flg), .cmd_flg(cmd_flg), .xmit_flg(xmit_flg),
      .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_end(byte_end),
      .parse_err(parse_err), .exec_done(exec_done), .fuse_id(FUSE),
      .state_o(state_o), .eng_rst_o(eng_rst_o), .resp_req_o(resp_req_o),
      .resp_kind_o(resp_kind_o), .resp_code_o(resp_code_o));

   function automatic string tag_of(logic [2:0] s);
      case (s)
         S_SLP:   return "R2";
         S_IDL:   return "R3";
         S_RCV:   return "R9";
         S_BSY:   return "R7";
         default: return "R11";
      endcase
   endfunction

   task automatic resp(logic [1:0] k, logic [7:0] c);
      e_req = 1'b1; e_kind = k; e_code = c;
   endtask

   task automatic model_step();
      logic exp;
      logic [7:0] eop;
      logic [3:0] ead;
      logic have;
      e_rst = 0; e_req = 0; e_kind = 0; e_code = 0;
      exp = (m_st != S_SLP) && (m_cnt == W - 1);
      if (m_st == S_SLP) begin
         if (wake_tok) begin
            m_st = S_IDL; m_cnt = 0; m_sync = 1; m_err = 0; m_res = 0;
         end
         return;
      end
      if (exp) begin
         m_st = S_SLP; e_rst = 1;
         return;
      end
      m_cnt++;
      case (m_st)
         S_IDL:
            if (sleep_flg) begin m_st = S_SLP; e_rst = 1; end
            else if (cmd_flg) begin m_st = S_RCV; m_nb = 0; m_err = 0; m_res = 0; end
            else if (xmit_flg) begin
               if (m_sync) begin resp(2'd1, 8'h11); m_sync = 0; end
               else if (m_err) resp(2'd2, 8'h03);
               else if (m_res) resp(2'd3, 8'h00);
            end
         S_RCV:
            if (sleep_flg) begin m_st = S_SLP; e_rst = 1; end
            else if (idle_flg) m_st = S_IDL;
            else if (byte_vld && byte_end) begin
               eop  = (m_nb == 0) ? byte_dat : m_op;
               have = (m_nb != 0);
               ead  = (m_nb == 1) ? byte_dat[3:0] : m_addr;
               if (parse_err) begin m_st = S_IDL; m_err = 1; end
               else if (eop == 8'h01) m_st = (!have || ead == FUSE) ? S_PAU : S_IDL;
               else m_st = S_BSY;
            end else if (byte_vld) begin
               if (m_nb == 0) m_op = byte_dat;
               if (m_nb == 1) m_addr = byte_dat[3:0];
               if (m_nb < 2) m_nb++;
            end
         S_BSY:
            if (sleep_flg) begin m_st = S_SLP; e_rst = 1; end
            else if (exec_done) begin m_st = S_IDL; m_res = 1; end
         default: ;
      endcase
   endtask

   task automatic check(string tag, logic ok, string what, int act, int expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   // inputs are set after a falling edge; one call covers one rising edge
   task automatic cyc(string tag);
      model_step();
      @(posedge clk);
      #1;
      cyc_n++;
      check(tag, {state_o, eng_rst_o, resp_req_o, resp_kind_o, resp_code_o} ==
                 {m_st, e_rst, e_req, e_kind, e_code}, "state/rst/req/kind/code",
            int'({state_o, eng_rst_o, resp_req_o, resp_kind_o, resp_code_o}),
            int'({m_st, e_rst, e_req, e_kind, e_code}));
      @(negedge clk);
      wake_tok = 0; sleep_flg = 0; idle_flg = 0; cmd_flg = 0; xmit_flg = 0;
      byte_vld = 0; byte_end = 0; parse_err = 0; exec_done = 0; byte_dat = '0;
   endtask

   task automatic send_byte(logic [7:0] b, logic last, logic perr, string tag);
      byte_vld = 1; byte_dat = b; byte_end = last; parse_err = perr;
      cyc(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int t_wake;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", {state_o, eng_rst_o, resp_req_o, resp_kind_o, resp_code_o} == '0,
            "reset outputs", int'(state_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 sleep ignores everything but wake
      xmit_flg = 1; cyc("R2");
      cmd_flg = 1; cyc("R2");
      sleep_flg = 1; cyc("R2");
      send_byte(8'h22, 1, 0, "R2");
      exec_done = 1; cyc("R2");
      check("R2", state_o == S_SLP, "still asleep", state_o, S_SLP);
      wake_tok = 1; cyc("R2");
      check("R2", state_o == S_IDL, "woken", state_o, S_IDL);
      // R3 sync byte
      xmit_flg = 1; cyc("R3");
      check("R3", resp_code_o == 8'h11 && resp_req_o, "sync code", resp_code_o, 8'h11);
      xmit_flg = 1; cyc("R3");
      // R7 / R8 normal command
      cmd_flg = 1; cyc("R7");
      send_byte(8'h22, 0, 0, "R7");
      send_byte(8'h33, 1, 0, "R7");
      check("R7", state_o == S_BSY, "busy", state_o, S_BSY);
      xmit_flg = 1; cyc("R7");
      exec_done = 1; cyc("R8");
      xmit_flg = 1; cyc("R8");
      check("R8", resp_kind_o == 2'd3, "result kind", resp_kind_o, 3);
      xmit_flg = 1; cyc("R8");
      // R6 format error
      cmd_flg = 1; cyc("R6");
      send_byte(8'h40, 1, 1, "R6");
      xmit_flg = 1; cyc("R6");
      check("R6", resp_code_o == 8'h03, "error code", resp_code_o, 8'h03);
      xmit_flg = 1; cyc("R6");
      // R10 address mismatch, then still accepts commands
      cmd_flg = 1; cyc("R10");
      send_byte(8'h01, 0, 0, "R10");
      send_byte(8'h05, 1, 0, "R10");
      check("R10", state_o == S_IDL, "mismatch stays idle", state_o, S_IDL);
      cmd_flg = 1; cyc("R10");
      send_byte(8'h44, 1, 0, "R10");
      // R4 sleep flag in busy
      sleep_flg = 1; cyc("R4");
      check("R4", state_o == S_SLP && eng_rst_o, "sleep with reset", state_o, S_SLP);
      cyc("R4");
      // R12 idle flag
      wake_tok = 1; cyc("R12");
      t_wake = cyc_n;
      cmd_flg = 1; cyc("R12");
      send_byte(8'h01, 0, 0, "R12");
      idle_flg = 1; cyc("R12");
      idle_flg = 1; cyc("R12");
      check("R12", state_o == S_IDL, "idle after abort", state_o, S_IDL);
      // R9 matching pause, R11 deafness, R5 session length
      cmd_flg = 1; cyc("R9");
      send_byte(8'h01, 0, 0, "R9");
      send_byte(8'h3A, 1, 0, "R9");
      check("R9", state_o == S_PAU, "paused", state_o, S_PAU);
      wake_tok = 1; cyc("R11");
      xmit_flg = 1; cyc("R11");
      sleep_flg = 1; cyc("R11");
      cmd_flg = 1; cyc("R11");
      send_byte(8'h22, 1, 0, "R11");
      exec_done = 1; cyc("R11");
      idle_flg = 1; cyc("R11");
      check("R11", state_o == S_PAU, "still paused", state_o, S_PAU);
      for (int i = 0; i < W + 10 && state_o != S_SLP; i++) cyc("R5");
      check("R5", cyc_n - t_wake == W, "awake cycles", cyc_n - t_wake, W);
      // R11 wake honoured after pause, R9 pause with no address
      wake_tok = 1; cyc("R11");
      check("R11", state_o == S_IDL, "wake after pause", state_o, S_IDL);
      cmd_flg = 1; cyc("R9");
      send_byte(8'h01, 1, 0, "R9");
      check("R9", state_o == S_PAU, "pause no address", state_o, S_PAU);
      for (int i = 0; i < W + 10 && state_o != S_SLP; i++) cyc("R5");
      // random phase
      for (int i = 0; i < 4000; i++) begin
         int r;
         string tg;
         r  = int'($urandom_range(99));
         tg = tag_of(m_st);
         if (m_st == S_SLP) begin
            if (r < 15) wake_tok = 1;
            else if (r < 30) xmit_flg = 1;
         end else if (r < 2) sleep_flg = 1;
         else if (r < 5) idle_flg = 1;
         else if (r < 20) cmd_flg = 1;
         else if (r < 38) xmit_flg = 1;
         else if (r < 48) exec_done = 1;
         else if (r < 85) begin
            int k;
            k = int'($urandom_range(2));
            byte_vld = 1;
            byte_dat = (k == 0) ? 8'h01 :
                       (k == 1) ? {4'($urandom_range(15)), ($urandom_range(1) != 0) ? FUSE : 4'($urandom_range(15))} :
                       8'($urandom_range(255));
            byte_end = ($urandom_range(2) == 0);
            parse_err = byte_end && ($urandom_range(9) == 0);
         end
         cyc(tg);
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule